// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from power-on to an operational state after a synchronous reset. It owns the clock-enable pin, the four active-low command strobes, the bank address and the row/column address bus. It then steps through a fixed order of events. First a clock-enable-low hold with COMMAND INHIBIT. Then a long stabilization window of NOPs with clock enable raised. After that comes a precharge of every bank, two auto-refresh commands and one mode register load. Each command is followed by NOP cycles that cover the required gap before the next one. A parameter places the two refreshes either before or after the mode register load.

Once the final gap has elapsed, `init_done` goes high and stays high. The sequencer then parks the command pins on NOP so that a normal access controller can take over the bus. All waits are parameters counted in clock cycles. The default stabilization length of 13,300 cycles covers 100 µs at 133 MHz.

The control core is a state machine with these states: `ST_CKE_LOW`, `ST_STABLE`, `ST_PRECHARGE`, `ST_WAIT_RP`, `ST_REFRESH_A`, `ST_WAIT_RFC_A`, `ST_REFRESH_B`, `ST_WAIT_RFC_B`, `ST_LOAD_MODE`, `ST_WAIT_MRD` and `ST_DONE`. Each state is left when a shared down-counter expires.

With refresh first (`REFRESH_FIRST`=1) the transitions are:
- CKE_LOW → STABLE → PRECHARGE → WAIT_RP
- WAIT_RP → REFRESH_A → WAIT_RFC_A → REFRESH_B → WAIT_RFC_B
- WAIT_RFC_B → LOAD_MODE → WAIT_MRD → DONE

With the mode load first (`REFRESH_FIRST`=0) the transitions are:
- CKE_LOW → STABLE → PRECHARGE → WAIT_RP
- WAIT_RP → LOAD_MODE → WAIT_MRD
- WAIT_MRD → REFRESH_A → WAIT_RFC_A → REFRESH_B → WAIT_RFC_B → DONE

A synchronous reset returns the machine to CKE_LOW from any state.

Top module: `sdram_pwrup_seq`

## Requirements
Positions are counted in clock edges after reset is released. Position 0 is the state during reset. Commands are encoded as {cs_n,ras_n,cas_n,we_n}: INHIBIT=1111, NOP=0111, PRECHARGE=0010, AUTO REFRESH=0001, LOAD MODE=0000. Unless stated otherwise, `ba` and `addr` are zero.
- R1: For positions 0 to T_CKE_LOW-1, `cke` is 0, the command is INHIBIT and `init_done` is 0.
- R2: From position T_CKE_LOW, `cke` is 1 and stays 1 until the next reset. Up to position T_STABLE-1 the command is NOP.
- R3: At position T_STABLE the command is PRECHARGE with `addr[10]`=1, all other address bits 0 and `ba`=0.
- R4: Exactly two AUTO REFRESH commands are issued, and the second follows the first by T_RFC cycles.
- R5: One LOAD MODE command is issued with `addr`=MODE_VALUE and `ba`=0.
- R6: With REFRESH_FIRST=1 the order is PRECHARGE, REFRESH, REFRESH, LOAD MODE; with REFRESH_FIRST=0 it is PRECHARGE, LOAD MODE, REFRESH, REFRESH. The next command comes T_RP cycles after a precharge, T_RFC after a refresh and T_MRD after a mode load.
- R7: Every cycle between two commands carries NOP with `cke`=1 and a zero address.
- R8: `init_done` rises one gap (T_RFC or T_MRD, according to the last command) after the last command. It then stays 1 with NOP on the pins.
- R9: A reset sampled at any position puts all outputs into the R1 state on that edge, and the whole sequence restarts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Row/column address bus |
| init_done | output | 1 | High once the sequence has completed |

## Verification
The hardest case to reach from the ports is a reset that lands deep inside the sequence: inside a short refresh or mode gap, on a single-cycle command, or just before `init_done` rises. A plain run only reaches those positions once, after the long stabilization window. The bench therefore draws reset moments from `$urandom` over the whole sequence length, with a fixed seed. It checks every cycle against a position-indexed model, both while reset is held and through the restart. A second instance with short waits and the mode load placed first runs alongside, so the reordered sequence and its gaps are checked in the same run.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_CKE_LOW,
        ST_STABLE,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH_A,
        ST_WAIT_RFC_A,
        ST_REFRESH_B,
        ST_WAIT_RFC_B,
        ST_LOAD_MODE,
        ST_WAIT_MRD,
        ST_DONE
    } init_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_INHIBIT   = 4'b1111,
        CMD_NOP       = 4'b0111,
        CMD_PRECHARGE = 4'b0010,
        CMD_REFRESH   = 4'b0001,
        CMD_LOAD_MODE = 4'b0000
    } sdram_cmd_t;

    localparam int ALL_BANKS_BIT = 10;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W     = 14,
    parameter int RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // once run out, the count stays at zero until reloaded (R7 gap timing)
    p_expiry_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int T_STABLE      = 13300,
    parameter int T_CKE_LOW     = 100,
    parameter int T_RP          = 3,
    parameter int T_RFC         = 9,
    parameter int T_MRD         = 2,
    parameter bit REFRESH_FIRST = 1'b1,
    parameter int CNT_W         = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             expired,
    output init_state_t      state,
    output init_state_t      nxt,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);

    // number of cycles a state is held, minus one
    function automatic logic [CNT_W-1:0] hold_m1(init_state_t s);
        unique case (s)
            ST_CKE_LOW:    hold_m1 = CNT_W'(T_CKE_LOW - 1);
            ST_STABLE:     hold_m1 = CNT_W'(T_STABLE - T_CKE_LOW - 1);
            ST_WAIT_RP:    hold_m1 = CNT_W'(T_RP - 2);
            ST_WAIT_RFC_A,
            ST_WAIT_RFC_B: hold_m1 = CNT_W'(T_RFC - 2);
            ST_WAIT_MRD:   hold_m1 = CNT_W'(T_MRD - 2);
            default:       hold_m1 = '0;
        endcase
    endfunction

    init_state_t state_q;

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_CKE_LOW:    if (expired) nxt = ST_STABLE;
            ST_STABLE:     if (expired) nxt = ST_PRECHARGE;
            ST_PRECHARGE:  if (expired) nxt = ST_WAIT_RP;
            ST_WAIT_RP:    if (expired) nxt = REFRESH_FIRST ? ST_REFRESH_A : ST_LOAD_MODE;
            ST_REFRESH_A:  if (expired) nxt = ST_WAIT_RFC_A;
            ST_WAIT_RFC_A: if (expired) nxt = ST_REFRESH_B;
            ST_REFRESH_B:  if (expired) nxt = ST_WAIT_RFC_B;
            ST_WAIT_RFC_B: if (expired) nxt = REFRESH_FIRST ? ST_LOAD_MODE : ST_DONE;
            ST_LOAD_MODE:  if (expired) nxt = ST_WAIT_MRD;
            ST_WAIT_MRD:   if (expired) nxt = REFRESH_FIRST ? ST_DONE : ST_REFRESH_A;
            ST_DONE:       nxt = ST_DONE;
            default:       nxt = ST_CKE_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_CKE_LOW;
        else     state_q <= nxt;
    end

    assign state    = state_q;
    assign load     = (nxt != state_q);
    assign load_val = hold_m1(nxt);

    // a state is only left once the shared timer has run out (R6 gaps)
    p_hold_until_expiry_r6: assert property (@(posedge clk) disable iff (rst)
        (!expired) |=> $stable(state_q));

    // precharge is always followed by its own gap state (R6)
    p_pre_then_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRECHARGE && expired) |=> (state_q == ST_WAIT_RP));

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int                ROW_W      = 13,
    parameter int                BANK_W     = 2,
    parameter logic [ROW_W-1:0]  MODE_VALUE = 13'h033
) (
    input  logic              clk,
    input  logic              rst,
    input  init_state_t       nxt,
    output logic              cke,
    output logic [3:0]        cmd,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic              init_done
);

    logic              cke_d;
    sdram_cmd_t        cmd_d;
    logic [ROW_W-1:0]  addr_d;
    logic              done_d;

    always_comb begin
        cke_d  = 1'b1;
        cmd_d  = CMD_NOP;
        addr_d = '0;
        done_d = 1'b0;
        unique case (nxt)
            ST_CKE_LOW: begin
                cke_d = 1'b0;
                cmd_d = CMD_INHIBIT;
            end
            ST_PRECHARGE: begin
                cmd_d                 = CMD_PRECHARGE;
                addr_d[ALL_BANKS_BIT] = 1'b1;
            end
            ST_REFRESH_A,
            ST_REFRESH_B: cmd_d = CMD_REFRESH;
            ST_LOAD_MODE: begin
                cmd_d  = CMD_LOAD_MODE;
                addr_d = MODE_VALUE;
            end
            ST_DONE:      done_d = 1'b1;
            default:      cmd_d  = CMD_NOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke       <= 1'b0;
            cmd       <= CMD_INHIBIT;
            ba        <= '0;
            addr      <= '0;
            init_done <= 1'b0;
        end else begin
            cke       <= cke_d;
            cmd       <= cmd_d;
            ba        <= '0;
            addr      <= addr_d;
            init_done <= done_d;
        end
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int               ROW_W         = 13,
    parameter int               BANK_W        = 2,
    parameter int               T_STABLE      = 13300,
    parameter int               T_CKE_LOW     = 100,
    parameter int               T_RP          = 3,
    parameter int               T_RFC         = 9,
    parameter int               T_MRD         = 2,
    parameter bit               REFRESH_FIRST = 1'b1,
    parameter logic [ROW_W-1:0] MODE_VALUE    = 13'h033
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic              init_done
);

    localparam int CNT_W = $clog2(T_STABLE + 1) + 1;

    init_state_t      state;
    init_state_t      nxt;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic [3:0]       cmd;

    sdram_init_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (T_CKE_LOW - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sdram_init_fsm #(
        .T_STABLE      (T_STABLE),
        .T_CKE_LOW     (T_CKE_LOW),
        .T_RP          (T_RP),
        .T_RFC         (T_RFC),
        .T_MRD         (T_MRD),
        .REFRESH_FIRST (REFRESH_FIRST),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .expired  (expired),
        .state    (state),
        .nxt      (nxt),
        .load     (load),
        .load_val (load_val)
    );

    sdram_cmd_drive #(
        .ROW_W      (ROW_W),
        .BANK_W     (BANK_W),
        .MODE_VALUE (MODE_VALUE)
    ) u_drive (
        .clk       (clk),
        .rst       (rst),
        .nxt       (nxt),
        .cke       (cke),
        .cmd       (cmd),
        .ba        (ba),
        .addr      (addr),
        .init_done (init_done)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    // clock enable low only ever comes with the chip deselected
    p_cke_low_inhibit_r1: assert property (@(posedge clk) disable iff (rst)
        (!cke) |-> (cs_n && ras_n && cas_n && we_n));

    // once raised, clock enable stays up until reset
    p_cke_stays_high_r2: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    // precharge always targets all banks
    p_precharge_all_r3: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && cas_n && !we_n) |-> addr[ALL_BANKS_BIT]);

    // mode load carries the configured value on bank zero
    p_mode_value_r5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && !cas_n && !we_n) |-> (addr == MODE_VALUE && ba == '0));

    // any command is followed by at least one NOP
    p_gap_after_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !(ras_n && cas_n && we_n)) |=> (!cs_n && ras_n && cas_n && we_n));

    // completion is sticky and parks the bus on NOP
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_done_nop_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cke && !cs_n && ras_n && cas_n && we_n && addr == '0));

    // the state register only sits in ST_DONE when the flag shows it
    p_done_matches_state_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |-> init_done);

endmodule

// File: tb/test_sdram_pwrup_seq.sv
module test_sdram_pwrup_seq;

    localparam int          A_TS = 13300, A_TCL = 100, A_TRP = 3, A_TRFC = 9, A_TMRD = 2;
    localparam bit          A_RF = 1'b1;
    localparam logic [12:0] A_MODE = 13'h033;
    localparam int          B_TS = 40, B_TCL = 7, B_TRP = 2, B_TRFC = 5, B_TMRD = 3;
    localparam bit          B_RF = 1'b0;
    localparam logic [12:0] B_MODE = 13'h1A5;
    localparam int          WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0] a_ba;
    logic [12:0] a_addr;
    logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0] b_ba;
    logic [12:0] b_addr;

    sdram_pwrup_seq i_sdram_pwrup_seq (
        .clk(clk), .rst(rst), .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras),
        .cas_n(a_cas), .we_n(a_we), .ba(a_ba), .addr(a_addr), .init_done(a_done)
    );

    sdram_pwrup_seq #(
        .T_STABLE(B_TS), .T_CKE_LOW(B_TCL), .T_RP(B_TRP), .T_RFC(B_TRFC),
        .T_MRD(B_TMRD), .REFRESH_FIRST(B_RF), .MODE_VALUE(B_MODE)
    ) i_sdram_pwrup_seq_mode_first (
        .clk(clk), .rst(rst), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras),
        .cas_n(b_cas), .we_n(b_we), .ba(b_ba), .addr(b_addr), .init_done(b_done)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    int  pos      = 0;
    int  cycles   = 0;
    bit  rst_seen = 1'b0;
    bit  started  = 1'b0;

    // kind: 0 inhibit, 1 stabilizing NOP, 2 precharge, 3 refresh, 4 mode load, 5 gap NOP, 6 done
    function automatic int kind_of(int p, int ts, int tcl, int trp, int trfc, int tmrd, bit rf);
        int c1, c2, c3, fin;
        if (p < tcl) return 0;
        if (p < ts) return 1;
        if (p == ts) return 2;
        c1 = ts + trp;
        if (rf) begin
            c2 = c1 + trfc; c3 = c2 + trfc; fin = c3 + tmrd;
            if (p == c1 || p == c2) return 3;
            if (p == c3) return 4;
        end else begin
            c2 = c1 + tmrd; c3 = c2 + trfc; fin = c3 + trfc;
            if (p == c1) return 4;
            if (p == c2 || p == c3) return 3;
        end
        if (p >= fin) return 6;
        return 5;
    endfunction

    // packed as {cke, cs_n, ras_n, cas_n, we_n, ba, addr, init_done}
    function automatic logic [20:0] vec_of(int k, logic [12:0] mode);
        case (k)
            0:       return {1'b0, 4'b1111, 2'b00, 13'h0, 1'b0};
            2:       return {1'b1, 4'b0010, 2'b00, 13'h0400, 1'b0};
            3:       return {1'b1, 4'b0001, 2'b00, 13'h0, 1'b0};
            4:       return {1'b1, 4'b0000, 2'b00, mode, 1'b0};
            6:       return {1'b1, 4'b0111, 2'b00, 13'h0, 1'b1};
            default: return {1'b1, 4'b0111, 2'b00, 13'h0, 1'b0};
        endcase
    endfunction

    function automatic string tag_of(int k, bit rf, bit in_rst);
        if (in_rst) return "R9";
        case (k)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return rf ? "R4" : "R6";
            4: return rf ? "R5" : "R6";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check_one(string name, logic [20:0] act, int k, logic [12:0] mode, bit rf);
        logic [20:0] exp;
        exp = vec_of(k, mode);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s pos=%0d actual=%h expected=%h",
                     tag_of(k, rf, rst_seen), name, pos, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // position model: reset puts it at 0, each released edge advances it (R9)
    always @(posedge clk) begin
        cycles++;
        rst_seen <= rst;
        started  <= 1'b1;
        if (rst) pos <= 0;
        else     pos <= pos + 1;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    end

    // every cycle both instances are compared against the model, away from the edge
    always @(negedge clk) begin
        if (started) begin
            check_one("A", {a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done},
                      kind_of(pos, A_TS, A_TCL, A_TRP, A_TRFC, A_TMRD, A_RF), A_MODE, A_RF);
            check_one("B", {b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done},
                      kind_of(pos, B_TS, B_TCL, B_TRP, B_TRFC, B_TMRD, B_RF), B_MODE, B_RF);
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // full directed run through both sequences to done (R1-R8)
        repeat (A_TS + 60) @(negedge clk);
        // directed: reset on the mode-first instance's first refresh and on A's precharge (R9)
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (B_TS + B_TRP + B_TMRD) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (A_TS) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // random reset moments over the whole sequence (R9)
        for (int i = 0; i < 6; i++) begin
            int run_len;
            int hold;
            run_len = $urandom_range(1, A_TS + 40);
            if (i == 0) run_len = A_TS + A_TRP + A_TRFC + 2;
            hold = $urandom_range(1, 3);
            repeat (run_len) @(negedge clk);
            rst = 1'b1;
            repeat (hold) @(negedge clk);
            rst = 1'b0;
        end
        // final full run to completion and well beyond (R8)
        repeat (A_TS + 80) @(negedge clk);
        finish_run();
    end

endmodule